// File: doc/BRIEF.md
# Sequential-Fetch Branch Squash Controller

This block carries out a fall-through branch policy for a five-stage pipeline (fetch, decode, execute, memory, writeback). Fetch always continues along the sequential path, so a branch that is not taken costs no cycles. The branch decision and the branch target only become known when the branch reaches the memory stage. If the branch is taken there, the three instructions behind it are on the wrong path. The controller then sends fetch to the target and turns those three instructions into no-ops.

Each of the three wrong-path instructions is cancelled in a different way. The one in the fetch/decode register has its instruction word cleared to zero. The one in decode is turned into a bubble by the same control-zeroing line that a load-use stall uses. The one in execute has its destination register forced to register 0, and its register-write and memory-write enables removed, so it changes no state. The controller owns the fetch PC register. It also resolves the conflict between a taken branch and a load-use stall that arrive in the same cycle.

The squash and override outputs are combinational, so they act on the pipeline registers at the same clock edge. The fetch PC is registered.

Top module: `branch_flush_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, `fetch_pc` loads `RESET_PC`. With no branch and no stall, the outputs `ifid_clear`, `idex_ctrl_clear`, `ifid_hold` and `pc_hold` are all 0.
- R2: When `br_taken_m` is 0 and `load_use_stall` is 0, `fetch_pc` increases by `INST_BYTES` (modulo 2^ADDR_W) at the next edge. No clear or hold output is asserted, so a fall-through branch costs nothing.
- R3: When `br_taken_m` is 1, `fetch_pc` equals `br_target_m` after the next clock edge. `pc_src` is 1 in that cycle, and 1 means target and 0 means sequential.
- R4: When `br_taken_m` is 1, `ifid_clear` is 1 in the same cycle, which zeroes the instruction word in fetch/decode.
- R5: When `br_taken_m` is 1, `idex_ctrl_clear` is 1 in the same cycle, which cancels the instruction in decode.
- R6: When `br_taken_m` is 1, the following hold whatever the inputs: `ex_rd_out` is 0, `ex_regwrite_out` is 0 and `ex_memwrite_out` is 0.
- R7: When `br_taken_m` is 0, `ex_rd_out`, `ex_regwrite_out` and `ex_memwrite_out` equal `ex_rd_in`, `ex_regwrite_in` and `ex_memwrite_in`.
- R8: When `load_use_stall` is 1 and `br_taken_m` is 0, the following hold: `fetch_pc` keeps its value, `pc_hold` and `ifid_hold` are 1, `idex_ctrl_clear` is 1, `ifid_clear` is 0 and `pc_src` is 0.
- R9: When `br_taken_m` and `load_use_stall` are both 1, the flush wins. `pc_hold` and `ifid_hold` are 0, and `fetch_pc` takes `br_target_m` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_taken_m | input | 1 | Branch in memory stage resolved taken |
| br_target_m | input | ADDR_W | Branch target from memory stage |
| load_use_stall | input | 1 | Load-use stall request from decode |
| ex_rd_in | input | REG_AW | Destination register of the instruction in execute |
| ex_regwrite_in | input | 1 | Register-write enable of the instruction in execute |
| ex_memwrite_in | input | 1 | Memory-write enable of the instruction in execute |
| fetch_pc | output | ADDR_W | Registered fetch address |
| pc_src | output | 1 | Next-PC select, 1 = branch target |
| pc_hold | output | 1 | PC write suppressed this cycle |
| ifid_hold | output | 1 | Fetch/decode register write suppressed |
| ifid_clear | output | 1 | Zero the fetch/decode instruction word |
| idex_ctrl_clear | output | 1 | Zero the decode/execute control fields |
| ex_rd_out | output | REG_AW | Execute destination after override |
| ex_regwrite_out | output | 1 | Execute register-write after override |
| ex_memwrite_out | output | 1 | Execute memory-write after override |

## Verification
The bench builds the block with ADDR_W=8, REG_AW=3, INST_BYTES=4 and RESET_PC=0x10. The 3-bit register field makes every destination value reachable, so the zero override and the pass-through are both checked for all eight register numbers. The sweep covers every combination of taken, stall and the two write enables, each paired with every register value. The 8-bit PC wraps within the run, so sequential advance past the top of the address space is also exercised.

// File: rtl/flush_pkg.sv
package flush_pkg;
  typedef enum logic [1:0] {
    NPC_SEQ    = 2'd0,
    NPC_HOLD   = 2'd1,
    NPC_TARGET = 2'd2
  } npc_mode_e;
endpackage

// File: rtl/flush_squash_ctl.sv
module flush_squash_ctl
  import flush_pkg::*;
(
  input  logic      taken,
  input  logic      stall,
  output npc_mode_e npc_mode,
  output logic      ifid_clear,
  output logic      ifid_hold,
  output logic      idex_clear
);
  logic stall_eff;

  // a taken branch overrides a simultaneous load-use stall
  assign stall_eff  = stall & ~taken;
  assign ifid_clear = taken;
  assign ifid_hold  = stall_eff;
  assign idex_clear = taken | stall_eff;

  always_comb begin
    if (taken)          npc_mode = NPC_TARGET;
    else if (stall_eff) npc_mode = NPC_HOLD;
    else                npc_mode = NPC_SEQ;
  end
endmodule

// File: rtl/flush_pc_reg.sv
module flush_pc_reg
  import flush_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          INST_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  npc_mode_e         npc_mode,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INST_BYTES);

  logic [ADDR_W-1:0] pc_next;

  always_comb begin
    case (npc_mode)
      NPC_TARGET: pc_next = target;
      NPC_HOLD:   pc_next = pc;
      default:    pc_next = pc + STEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC;
    else     pc <= pc_next;
  end
endmodule

// File: rtl/flush_ex_kill.sv
module flush_ex_kill #(
  parameter int REG_AW = 5
) (
  input  logic              kill,
  input  logic [REG_AW-1:0] rd_in,
  input  logic              regwrite_in,
  input  logic              memwrite_in,
  output logic [REG_AW-1:0] rd_out,
  output logic              regwrite_out,
  output logic              memwrite_out
);
  // each destination bit is gated so the write lands on register 0
  for (genvar b = 0; b < REG_AW; b++) begin : g_rd_gate
    assign rd_out[b] = rd_in[b] & ~kill;
  end
  assign regwrite_out = regwrite_in & ~kill;
  assign memwrite_out = memwrite_in & ~kill;
endmodule

// File: rtl/branch_flush_ctl.sv
module branch_flush_ctl
  import flush_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          REG_AW     = 5,
  parameter int          INST_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_taken_m,
  input  logic [ADDR_W-1:0] br_target_m,
  input  logic              load_use_stall,
  input  logic [REG_AW-1:0] ex_rd_in,
  input  logic              ex_regwrite_in,
  input  logic              ex_memwrite_in,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic              pc_src,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              ifid_clear,
  output logic              idex_ctrl_clear,
  output logic [REG_AW-1:0] ex_rd_out,
  output logic              ex_regwrite_out,
  output logic              ex_memwrite_out
);
  npc_mode_e npc_mode;

  flush_squash_ctl u_squash (
    .taken      (br_taken_m),
    .stall      (load_use_stall),
    .npc_mode   (npc_mode),
    .ifid_clear (ifid_clear),
    .ifid_hold  (ifid_hold),
    .idex_clear (idex_ctrl_clear)
  );

  flush_pc_reg #(
    .ADDR_W     (ADDR_W),
    .INST_BYTES (INST_BYTES),
    .RESET_PC   (RESET_PC)
  ) u_pc (
    .clk      (clk),
    .rst      (rst),
    .npc_mode (npc_mode),
    .target   (br_target_m),
    .pc       (fetch_pc)
  );

  flush_ex_kill #(.REG_AW(REG_AW)) u_kill (
    .kill         (br_taken_m),
    .rd_in        (ex_rd_in),
    .regwrite_in  (ex_regwrite_in),
    .memwrite_in  (ex_memwrite_in),
    .rd_out       (ex_rd_out),
    .regwrite_out (ex_regwrite_out),
    .memwrite_out (ex_memwrite_out)
  );

  assign pc_src  = (npc_mode == NPC_TARGET);
  assign pc_hold = (npc_mode == NPC_HOLD);
endmodule

// File: rtl/branch_flush_ctl_checker.sv
module branch_flush_ctl_checker #(
  parameter int ADDR_W     = 32,
  parameter int REG_AW     = 5,
  parameter int INST_BYTES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              br_taken_m,
  input logic [ADDR_W-1:0] br_target_m,
  input logic              load_use_stall,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              pc_hold,
  input logic              ifid_hold,
  input logic              ifid_clear,
  input logic              idex_ctrl_clear,
  input logic [REG_AW-1:0] ex_rd_out,
  input logic              ex_regwrite_out,
  input logic              ex_memwrite_out
);
  p_seq_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (!br_taken_m && !load_use_stall) |=>
      fetch_pc == ADDR_W'($past(fetch_pc) + ADDR_W'(INST_BYTES)));

  p_redirect_r3: assert property (@(posedge clk) disable iff (rst)
    br_taken_m |=> fetch_pc == $past(br_target_m));

  p_ifid_clear_r4: assert property (@(posedge clk) disable iff (rst)
    br_taken_m |-> ifid_clear);

  p_idex_clear_r5: assert property (@(posedge clk) disable iff (rst)
    br_taken_m |-> idex_ctrl_clear);

  p_ex_kill_r6: assert property (@(posedge clk) disable iff (rst)
    br_taken_m |-> (ex_rd_out == '0 && !ex_regwrite_out && !ex_memwrite_out));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (load_use_stall && !br_taken_m) |=> $stable(fetch_pc));

  p_flush_wins_r9: assert property (@(posedge clk) disable iff (rst)
    br_taken_m |-> (!pc_hold && !ifid_hold));
endmodule

bind branch_flush_ctl branch_flush_ctl_checker #(
  .ADDR_W(ADDR_W), .REG_AW(REG_AW), .INST_BYTES(INST_BYTES)
) u_checker (
  .clk(clk), .rst(rst), .br_taken_m(br_taken_m), .br_target_m(br_target_m),
  .load_use_stall(load_use_stall), .fetch_pc(fetch_pc), .pc_hold(pc_hold),
  .ifid_hold(ifid_hold), .ifid_clear(ifid_clear), .idex_ctrl_clear(idex_ctrl_clear),
  .ex_rd_out(ex_rd_out), .ex_regwrite_out(ex_regwrite_out),
  .ex_memwrite_out(ex_memwrite_out)
);

// File: tb/branch_flush_ctl_bench.sv
`timescale 1ns/1ps
module branch_flush_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int RW = 3;
  localparam int STEP = 4;
  localparam logic [AW-1:0] RST_PC = 8'h10;

  logic clk = 1'b0;
  logic rst;
  logic taken, stall, rw_in, mw_in;
  logic [AW-1:0] target;
  logic [RW-1:0] rd_in;
  logic [AW-1:0] fetch_pc;
  logic pc_src, pc_hold, ifid_hold, ifid_clear, idex_clear;
  logic [RW-1:0] rd_out;
  logic rw_out, mw_out;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] model_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_flush_ctl #(
    .ADDR_W(AW), .REG_AW(RW), .INST_BYTES(STEP), .RESET_PC(RST_PC)
  ) u_branch_flush_ctl (
    .clk(clk), .rst(rst), .br_taken_m(taken), .br_target_m(target),
    .load_use_stall(stall), .ex_rd_in(rd_in), .ex_regwrite_in(rw_in),
    .ex_memwrite_in(mw_in), .fetch_pc(fetch_pc), .pc_src(pc_src),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .ifid_clear(ifid_clear),
    .idex_ctrl_clear(idex_clear), .ex_rd_out(rd_out),
    .ex_regwrite_out(rw_out), .ex_memwrite_out(mw_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; taken = 0; stall = 0; rw_in = 0; mw_in = 0; target = '0; rd_in = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset value and idle controls
    check("R1 pc", 32'(fetch_pc), 32'(RST_PC));
    check("R1 ctl", {ifid_clear, idex_clear, ifid_hold, pc_hold}, 0);
    @(negedge clk);
    rst = 1'b0;
    model_pc = RST_PC;
    // sweep taken x stall x regwrite x memwrite x rd, repeated twice for PC wrap
    for (int pass = 0; pass < 2; pass++) begin
      for (int c = 0; c < 128; c++) begin
        logic t, s, rw, mw;
        logic [RW-1:0] rd;
        logic [AW-1:0] tg;
        t = c[6]; s = c[5]; rw = c[4]; mw = c[3]; rd = c[2:0];
        tg = AW'(c * 37 + pass * 91 + 3);
        taken = t; stall = s; rw_in = rw; mw_in = mw; rd_in = rd; target = tg;
        #1;
        if (t) begin
          check("R3 pc_src", 32'(pc_src), 1);
          check("R4 ifid_clear", 32'(ifid_clear), 1);
          check("R5 idex_clear", 32'(idex_clear), 1);
          check("R6 ex kill", {rd_out, rw_out, mw_out}, 0);
          if (s) check("R9 no hold", {pc_hold, ifid_hold}, 0);
        end else begin
          check("R7 pass", {rd_out, rw_out, mw_out}, {rd, rw, mw});
          check("R4 no clear", 32'(ifid_clear), 0);
          check("R3 pc_src seq", 32'(pc_src), 0);
          if (s) check("R8 hold", {pc_hold, ifid_hold, idex_clear}, 3'b111);
          else   check("R2 idle", {pc_hold, ifid_hold, idex_clear}, 0);
        end
        if (t)      model_pc = tg;
        else if (!s) model_pc = AW'(model_pc + AW'(STEP));
        @(posedge clk);
        #1;
        if (t)      check(s ? "R9 pc" : "R3 pc", 32'(fetch_pc), 32'(model_pc));
        else if (s) check("R8 pc", 32'(fetch_pc), 32'(model_pc));
        else        check("R2 pc", 32'(fetch_pc), 32'(model_pc));
        @(negedge clk);
      end
    end
    // long sequential run to cross the address wrap (R2)
    taken = 0; stall = 0;
    for (int k = 0; k < 70; k++) begin
      model_pc = AW'(model_pc + AW'(STEP));
      @(posedge clk); #1;
      check("R2 wrap", 32'(fetch_pc), 32'(model_pc));
      @(negedge clk);
    end
    // reset mid-run returns to RESET_PC (R1)
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1 rerst", 32'(fetch_pc), 32'(RST_PC));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule